// File: doc/BRIEF.md
# Addressable Bit Register with Decode Mode

This block holds a row of single-bit outputs that can be written one at a time by address. A data bit, a binary index, an active-low write strobe and an active-low clear are sampled on each rising clock edge. The strobe and the clear together pick one of four modes. In single-bit write mode only the indexed bit changes. In hold mode every bit keeps its value. In decode mode the indexed bit takes the data value and every other bit goes low, so the block works as a one-hot decoder when the data is held high. In clear mode every bit goes low.

The bits are flops, not transparent latches, so the outputs change only on the clock edge. A separate synchronous power-on reset also clears every bit. Whatever a mode leaves on the outputs stays there as stored state once the block returns to hold mode.

Top module: `addr_bitreg`

## Requirements
- R1: A cycle with `rst` high sets every bit of `q` to 0 at that clock edge, whatever the other inputs are.
- R2: With `wr_n`=0 and `clr_n`=1, bit `q[sel]` takes `din` at the clock edge. Every other bit keeps its value.
- R3: With `wr_n`=1 and `clr_n`=1, every bit of `q` keeps its value, whatever `din` and `sel` are.
- R4: With `wr_n`=0 and `clr_n`=0, `q` becomes `din << sel` at the clock edge. The indexed bit equals `din` and all other bits are 0.
- R5: With `wr_n`=1 and `clr_n`=0, `q` becomes all zeros at the clock edge, whatever `din` and `sel` are.
- R6: After decode mode, the next hold cycles keep the decoded pattern: the indexed bit equals `din` and the other bits are 0.
- R7: With `din`=1 held high, decode mode gives a one-hot `q` whose set bit is at position `sel`, for every value of `sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every update happens on its rising edge |
| rst | input | 1 | Synchronous power-on reset, active high |
| din | input | 1 | Data bit to store or route |
| sel | input | 3 | Index of the target output bit (W = 2^3 bits by default) |
| wr_n | input | 1 | Write strobe, active low |
| clr_n | input | 1 | Clear, active low; combined with `wr_n` low it selects decode mode |
| q | output | 8 | Stored bits, active high |

## Verification
Each result is due in the first cycle after the edge that samples the inputs. There is exactly one register stage between the inputs and `q`, and `q` does not depend on the inputs in any other way. The bench changes its inputs on the falling edge, applies the mode rules to its own eight-bit model at the rising edge, and compares `q` with the model one quarter period after that edge. Before each rising edge, it checks that `q` still holds the previous value, so no combinational path from the inputs to `q` can go unnoticed.

// File: rtl/addr_bitreg.sv
module addr_bitreg #(
  parameter int AW = 3,
  localparam int W = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  input  logic [AW-1:0] sel,
  input  logic          wr_n,
  input  logic          clr_n,
  output logic [W-1:0]  q
);

  logic [W-1:0] hit;
  logic [W-1:0] q_nxt;

  assign hit = W'(1) << sel;

  always_comb begin
    unique case ({wr_n, clr_n})
      2'b01:   q_nxt = (q & ~hit) | (din ? hit : '0);
      2'b11:   q_nxt = q;
      2'b00:   q_nxt = din ? hit : '0;
      default: q_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end

endmodule

// File: rtl/addr_bitreg_chk.sv
module addr_bitreg_chk #(
  parameter int AW = 3,
  localparam int W = 1 << AW
) (
  input logic          clk,
  input logic          rst,
  input logic          din,
  input logic [AW-1:0] sel,
  input logic          wr_n,
  input logic          clr_n,
  input logic [W-1:0]  q
);

  p_reset_clears_r1: assert property (@(posedge clk) rst |=> q == '0);

  p_write_one_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && clr_n) |=> (q[$past(sel)] == $past(din)) &&
      ((q & ~(W'(1) << $past(sel))) == ($past(q) & ~(W'(1) << $past(sel)))));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_n && clr_n) |=> $stable(q));

  p_decode_r4: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !clr_n) |=> q == ($past(din) ? (W'(1) << $past(sel)) : '0));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_n && !clr_n) |=> q == '0);

  p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !clr_n && din) |=> $countones(q) == 1);

  p_decode_few_r4: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !clr_n) |=> $onehot0(q));

endmodule

bind addr_bitreg addr_bitreg_chk #(.AW(AW)) u_chk (.*);

// File: tb/addr_bitreg_bench.sv
module addr_bitreg_bench;
  logic clk = 0, rst = 1, din = 0, wr_n = 1, clr_n = 1;
  logic [2:0] sel = 0;
  logic [7:0] q, model;
  int checks = 0, errors = 0;
  bit done = 0;

  addr_bitreg u_addr_bitreg (.clk, .rst, .din, .sel, .wr_n, .clr_n, .q);

  always #2 clk = ~clk;

  function automatic logic [7:0] next_val(logic [7:0] cur, logic r, logic d,
                                          logic [2:0] s, logic w, logic c);
    logic [7:0] n = cur;
    if (r) return 8'h00;
    if (!w && c) n[s] = d;
    else if (!w && !c) n = d ? (8'h01 << s) : 8'h00;
    else if (w && !c) n = 8'h00;
    return n;
  endfunction

  task automatic check(string req, logic [7:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: q=%h expected=%h", req, q, exp);
    end
  endtask

  function automatic string tag(logic r, logic w, logic c);
    if (r) return "R1";
    case ({w, c})
      2'b01: return "R2";
      2'b11: return "R3";
      2'b00: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic step(logic r, logic d, logic [2:0] s, logic w, logic c);
    @(negedge clk);
    rst = r; din = d; sel = s; wr_n = w; clr_n = c;
    #1.5 check("R3 no early change", model);
    @(posedge clk);
    model = next_val(model, r, d, s, w, c);
    #1 check(tag(r, w, c), model);
  endtask

  initial begin
    model = 8'h00;
    step(1, 1, 3'd5, 0, 1);
    step(1, 0, 0, 1, 1);
    check("R1 reset state", 8'h00);
    for (int i = 0; i < 8; i++) begin
      step(0, 1, 3'(i), 0, 0);
      check("R7 one-hot", 8'h01 << i);
    end
    step(0, 1, 3'd6, 0, 0);
    step(0, 1, 3'd2, 1, 1);
    step(0, 0, 3'd6, 1, 1);
    check("R6 hold after decode", 8'h40);
    step(0, 1, 3'd0, 0, 1);
    step(0, 1, 3'd7, 0, 1);
    check("R2 writes accumulate", 8'hC1);
    step(0, 0, 3'd0, 0, 1);
    check("R2 write zero", 8'hC0);
    step(0, 1, 3'd3, 1, 0);
    check("R5 clear", 8'h00);
    step(0, 1, 3'd4, 0, 1);
    step(0, 0, 3'd4, 0, 0);
    check("R4 decode with din low", 8'h00);
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      int m = $urandom_range(0, 99);
      step(m < 2, 1'($urandom), 3'($urandom), m < 55 ? 1'b1 : 1'($urandom),
           m < 85 ? 1'b1 : 1'b0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule